// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block is a byte-wide static memory in which every word has a nonvolatile shadow copy. A host uses it like an ordinary SRAM through an address, a write-data and a read-data bus, with chip-enable, output-enable and write-enable controls. All controls are sampled on the clock. Reads see the addressed word combinationally. Writes land on the rising edge.

Whole-array transfers between the working array and the shadow array run in a second mode. A STORE copies the working array into the shadow array. A RECALL first clears the working array and then copies the shadow array back into it. Two things start a transfer: a rising edge on one of the sideband power inputs, or a fixed series of six host reads whose last address selects the direction. While a transfer runs, `busy` is high, the host is locked out and the read bus is never enabled. The engine handles one word per clock.

The full-size part has `ADDR_W = 15` (32768 words). The default parameter is smaller so that the block elaborates quickly. Unlock addresses are the low `ADDR_W` bits of the 15-bit keys 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, followed by 0x0FC0 for STORE or 0x0C63 for RECALL.

Top module: `nv_shadow_mem`

## Requirements
- R1: The working array holds 2^ADDR_W words of DATA_W bits, and a read returns the last value written to that address.
- R2: A write takes effect on the clock edge when `chip_en` and `wr_en` are both high and `busy` is low.
- R3: A rising edge on `pwr_fail` while idle starts a STORE, and `busy` is high from the next cycle.
- R4: A rising edge on `pwr_up` while idle starts a RECALL, and `busy` is high from the next cycle.
- R5: Six consecutive read accesses to key addresses K0..K4 and then the STORE key start a STORE. Any other read, or any write, between steps aborts the series. Cycles with `chip_en` low do not count as accesses and do not abort it.
- R6: The same first five keys followed by the RECALL key start a RECALL.
- R7: A RECALL keeps `busy` high for 2·2^ADDR_W cycles. Afterwards every working word equals the shadow word. The shadow array is left unchanged, so repeated RECALLs give the same result.
- R8: A STORE keeps `busy` high for exactly 2^ADDR_W cycles, copying one word per cycle. `busy` drops on the cycle after the last word is copied.
- R9: While `busy` is high, host writes are ignored, `rdata_en` stays low, and new triggers are ignored.
- R10: `rdata_en` is high only when `chip_en` and `out_en` are high, `wr_en` is low and `busy` is low.
- R11: When triggers coincide in one cycle, a `pwr_fail` edge wins over a `pwr_up` edge, and a `pwr_up` edge wins over an unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Host word address |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Read data of the addressed word |
| rdata_en | output | 1 | High when the read bus would be driven |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| wr_en | input | 1 | Write enable, active high |
| pwr_up | input | 1 | Power-good indication; a rising edge requests RECALL |
| pwr_fail | input | 1 | Power-fail indication; a rising edge requests STORE |
| busy | output | 1 | High while a transfer runs |

## Verification
The hardest situation to reach from the ports is an unlock series that is broken at an inner step. A series broken by a stray read or write must not start a transfer. A series that only pauses with `chip_en` low must still start one. The bench plays the key reads with a stray write inserted after step three, and again with a stray read inserted after step five. It then plays the same series with idle gaps between steps. In each case it checks `busy` one cycle after the last key and checks the array contents afterwards. A fresh pattern is swept through the whole array before each transfer, so that the shadow contents can be told apart from the working contents.

// File: rtl/nvs_pkg.sv
// Package: shared types and unlock key constants for the shadowed SRAM.
// Assumes key addresses are truncated to the configured address width.
package nvs_pkg;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_STORE = 2'd1,
        XF_CLEAR = 2'd2,
        XF_LOAD  = 2'd3
    } xfer_state_t;

    localparam int KEY_STEPS = 6;

    // Full 15-bit key for step 0..4 of the series
    function automatic logic [14:0] key_word(input int step);
        case (step)
            0:       key_word = 15'h0E38;
            1:       key_word = 15'h31C7;
            2:       key_word = 15'h03E0;
            3:       key_word = 15'h3C1F;
            default: key_word = 15'h303F;
        endcase
    endfunction

    localparam logic [14:0] STORE_KEY  = 15'h0FC0;
    localparam logic [14:0] RECALL_KEY = 15'h0C63;

endpackage

// File: rtl/nvs_unlock.sv
// Module: unlock series detector.
// Watches host accesses (cycles with chip enable high while idle) and fires a
// one-cycle STORE or RECALL request after six matching reads. Any non-matching
// read or any write resets the series; idle cycles leave it untouched.
module nvs_unlock
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              chip_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              req_store,
    output logic              req_recall
);

    localparam int STEP_W = $clog2(KEY_STEPS);

    logic [ADDR_W-1:0] keys [KEY_STEPS-1];
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_d;
    logic              access;
    logic              is_read;
    logic [ADDR_W-1:0] store_k;
    logic [ADDR_W-1:0] recall_k;

    // Truncated key table, one entry per step
    for (genvar g = 0; g < KEY_STEPS - 1; g++) begin : g_keys
        localparam logic [14:0] FULL = key_word(g);
        assign keys[g] = FULL[ADDR_W-1:0];
    end

    assign store_k  = STORE_KEY[ADDR_W-1:0];
    assign recall_k = RECALL_KEY[ADDR_W-1:0];
    assign access   = chip_en && !hold;
    assign is_read  = access && !wr_en;

    // Next step of the series and the final-step requests
    always_comb begin
        step_d     = step_q;
        req_store  = 1'b0;
        req_recall = 1'b0;
        if (hold) begin
            step_d = '0;
        end else if (access) begin
            if (!is_read) begin
                step_d = '0;
            end else if (step_q == STEP_W'(KEY_STEPS - 1)) begin
                req_store  = (addr == store_k);
                req_recall = (addr == recall_k);
                step_d     = (addr == keys[0]) ? STEP_W'(1) : '0;
            end else if (addr == keys[step_q]) begin
                step_d = step_q + STEP_W'(1);
            end else if (addr == keys[0]) begin
                step_d = STEP_W'(1);
            end else begin
                step_d = '0;
            end
        end
    end

    // Series position register
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

endmodule

// File: rtl/nvs_xfer_engine.sv
// Module: bulk transfer sequencer.
// STORE copies each working word to the shadow array, one per clock. RECALL
// first clears each working word, then loads each from the shadow array.
// Assumes start requests arrive only while idle and are mutually exclusive.
module nvs_xfer_engine
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_store,
    input  logic              start_recall,
    output logic              busy,
    output logic [ADDR_W-1:0] idx,
    output logic              shadow_we,
    output logic              work_we,
    output logic              work_clear
);

    localparam logic [ADDR_W-1:0] LAST_IDX = '1;

    xfer_state_t state_q;
    logic [ADDR_W-1:0] idx_q;
    logic last;

    assign last       = (idx_q == LAST_IDX);
    assign busy       = (state_q != XF_IDLE);
    assign idx        = idx_q;
    assign shadow_we  = (state_q == XF_STORE);
    assign work_we    = (state_q == XF_CLEAR) || (state_q == XF_LOAD);
    assign work_clear = (state_q == XF_CLEAR);

    // Phase and word index sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                XF_IDLE: begin
                    idx_q <= '0;
                    if (start_store)       state_q <= XF_STORE;
                    else if (start_recall) state_q <= XF_CLEAR;
                end
                XF_STORE: begin
                    idx_q <= idx_q + 1'b1;
                    if (last) state_q <= XF_IDLE;
                end
                XF_CLEAR: begin
                    idx_q <= idx_q + 1'b1;
                    if (last) state_q <= XF_LOAD;
                end
                default: begin
                    idx_q <= idx_q + 1'b1;
                    if (last) state_q <= XF_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/nvs_arrays.sv
// Module: working and shadow storage.
// The working array has a host port plus an engine port; the engine port has
// priority (the top only lets the host write while idle). The shadow array is
// written only by the engine. Reads are combinational; arrays carry no reset.
module nvs_arrays #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_we,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] eng_idx,
    input  logic              eng_work_we,
    input  logic              eng_clear,
    input  logic              eng_shadow_we
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] work_mem   [DEPTH];
    logic [DATA_W-1:0] shadow_mem [DEPTH];
    logic [DATA_W-1:0] eng_wdata;

    assign host_rdata = work_mem[host_addr];
    assign eng_wdata  = eng_clear ? '0 : shadow_mem[eng_idx];

    // Working array update from engine or host
    always_ff @(posedge clk) begin
        if (eng_work_we)  work_mem[eng_idx]   <= eng_wdata;
        else if (host_we) work_mem[host_addr] <= host_wdata;
    end

    // Shadow array update from the STORE phase
    always_ff @(posedge clk) begin
        if (eng_shadow_we) shadow_mem[eng_idx] <= work_mem[eng_idx];
    end

endmodule

// File: rtl/nv_shadow_mem.sv
// Module: top of the shadowed SRAM.
// Joins the unlock detector, the transfer engine and the arrays. It also turns
// the power inputs into edge requests and applies trigger priority
// (power-fail, then power-up, then unlock). Power inputs are assumed to be
// synchronous to clk.
module nv_shadow_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en,
    input  logic              chip_en,
    input  logic              out_en,
    input  logic              wr_en,
    input  logic              pwr_up,
    input  logic              pwr_fail,
    output logic              busy
);

    logic fail_q, up_q;
    logic fail_rise, up_rise;
    logic unl_store, unl_recall;
    logic start_store, start_recall;
    logic [ADDR_W-1:0] eng_idx;
    logic eng_shadow_we, eng_work_we, eng_clear;

    // Previous levels of the power inputs for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            up_q   <= 1'b0;
        end else begin
            fail_q <= pwr_fail;
            up_q   <= pwr_up;
        end
    end

    assign fail_rise = pwr_fail && !fail_q;
    assign up_rise   = pwr_up && !up_q;

    // Trigger arbitration while idle
    always_comb begin
        start_store  = !busy && (fail_rise || (!up_rise && unl_store));
        start_recall = !busy && !fail_rise && (up_rise || unl_recall);
    end

    nvs_unlock #(.ADDR_W(ADDR_W)) unlock_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (busy),
        .chip_en    (chip_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .req_store  (unl_store),
        .req_recall (unl_recall)
    );

    nvs_xfer_engine #(.ADDR_W(ADDR_W)) engine_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_store  (start_store),
        .start_recall (start_recall),
        .busy         (busy),
        .idx          (eng_idx),
        .shadow_we    (eng_shadow_we),
        .work_we      (eng_work_we),
        .work_clear   (eng_clear)
    );

    nvs_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arrays_i (
        .clk           (clk),
        .host_addr     (addr),
        .host_wdata    (wdata),
        .host_we       (chip_en && wr_en && !busy),
        .host_rdata    (rdata),
        .eng_idx       (eng_idx),
        .eng_work_we   (eng_work_we),
        .eng_clear     (eng_clear),
        .eng_shadow_we (eng_shadow_we)
    );

    assign rdata_en = chip_en && out_en && !wr_en && !busy;

endmodule

// File: rtl/nvs_checker.sv
// Module: protocol checker for nv_shadow_mem, attached by bind.
// Tracks power-input edges and busy run length on its own registers.
module nvs_checker #(
    parameter int ADDR_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic chip_en,
    input logic wr_en,
    input logic pwr_up,
    input logic pwr_fail,
    input logic busy,
    input logic rdata_en
);

    localparam int N = 1 << ADDR_W;
    localparam int RUN_W = ADDR_W + 2;

    logic fprev, uprev;
    logic [RUN_W-1:0] run_len;
    logic frise, urise;

    assign frise = pwr_fail && !fprev;
    assign urise = pwr_up && !uprev;

    // Mirror of power-input history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fprev <= 1'b0;
            uprev <= 1'b0;
        end else begin
            fprev <= pwr_fail;
            uprev <= pwr_up;
        end
    end

    // Length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    AST_STORE_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (frise && !busy) |=> busy); // R3

    AST_RECALL_ON_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (urise && !busy) |=> busy); // R4

    AST_BUSY_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == RUN_W'(N) || run_len == RUN_W'(2 * N))); // R8

    AST_START_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frise || urise || (chip_en && !wr_en))); // R5

    AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rdata_en); // R9

endmodule

bind nv_shadow_mem nvs_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_en  (chip_en),
    .wr_en    (wr_en),
    .pwr_up   (pwr_up),
    .pwr_fail (pwr_fail),
    .busy     (busy),
    .rdata_en (rdata_en)
);

// File: tb/nv_shadow_mem_tb_top.sv
// Bench: sweeps the full default array with arithmetic patterns around
// STORE and RECALL transfers, and exercises the unlock series corner cases.
module nv_shadow_mem_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    localparam logic [AW-1:0] K0 = 8'h38, K1 = 8'hC7, K2 = 8'hE0,
                              K3 = 8'h1F, K4 = 8'h3F, KS = 8'hC0, KR = 8'h63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdata_en;
    logic chip_en = 1'b0, out_en = 1'b0, wr_en = 1'b0;
    logic pwr_up = 1'b0, pwr_fail = 1'b0;
    logic busy;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nv_shadow_mem #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rdata_en(rdata_en), .chip_en(chip_en), .out_en(out_en), .wr_en(wr_en),
        .pwr_up(pwr_up), .pwr_fail(pwr_fail), .busy(busy)
    );

    function automatic logic [DW-1:0] pat(input int sel, input int a);
        case (sel)
            0:       pat = DW'(a * 37 + 11);
            1:       pat = DW'(a ^ 8'hA5);
            default: pat = DW'(a * 5 + 200);
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        chip_en = 1'b0; out_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        addr = AW'(a); wdata = d; chip_en = 1'b1; wr_en = 1'b1; out_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input int a);
        addr = AW'(a); chip_en = 1'b1; wr_en = 1'b0; out_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic fill(input int sel);
        for (int a = 0; a < N; a++) wr(a, pat(sel, a));
        idle();
    endtask

    // Returns number of mismatching words against pattern sel
    task automatic sweep(input int sel, output int bad);
        bad = 0;
        for (int a = 0; a < N; a++) begin
            addr = AW'(a); chip_en = 1'b1; wr_en = 1'b0; out_en = 1'b1;
            #1;
            if (rdata !== pat(sel, a) || rdata_en !== 1'b1) bad++;
            @(negedge clk);
        end
        idle();
    endtask

    // Counts busy cycles; pokes the host port while busy (R9)
    task automatic run_busy(output int cycles, output int leaks);
        cycles = 0; leaks = 0;
        while (busy && cycles < 4 * N) begin
            addr = AW'(cycles); wdata = 8'hEE; chip_en = 1'b1;
            wr_en = cycles[0]; out_en = 1'b1;
            #1;
            if (rdata_en !== 1'b0) leaks++;
            cycles++;
            @(negedge clk);
        end
        idle();
    endtask

    task automatic series(input logic [AW-1:0] last);
        rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(last);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int bad, cyc, leaks;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(busy === 1'b0, "reset busy", busy, 0);
        check(rdata_en === 1'b0, "reset rdata_en", rdata_en, 0);
        @(negedge clk);

        // R1 R2: write and read back whole array
        fill(0);
        sweep(0, bad);
        check(bad == 0, "R1 readback", bad, 0);

        // R10: enable rule
        addr = 3; chip_en = 1; out_en = 0; wr_en = 0; #1;
        check(rdata_en === 1'b0, "R10 out_en low", rdata_en, 0);
        out_en = 1; chip_en = 0; #1;
        check(rdata_en === 1'b0, "R10 chip_en low", rdata_en, 0);
        @(negedge clk);
        wr(3, pat(0, 3)); // write with out_en low still legal
        addr = 3; chip_en = 1; wr_en = 1; out_en = 1; wdata = pat(0, 3); #1;
        check(rdata_en === 1'b0, "R10 wr_en high", rdata_en, 0);
        @(negedge clk); idle();

        // R2: write needs chip_en
        addr = 9; wdata = 8'h00; chip_en = 0; wr_en = 1; @(negedge clk); idle();
        rd(9); idle();
        addr = 9; chip_en = 1; out_en = 1; #1;
        check(rdata === pat(0, 9), "R2 no write without chip_en", rdata, pat(0, 9));
        idle();

        // R5: software STORE, R8 length, R9 lockout
        series(KS);
        check(busy === 1'b1, "R5 store unlock busy", busy, 1);
        run_busy(cyc, leaks);
        check(cyc == N, "R8 store busy length", cyc, N);
        check(leaks == 0, "R9 bus quiet during store", leaks, 0);
        sweep(0, bad);
        check(bad == 0, "R9 writes ignored during store", bad, 0);

        // R6 R7: software RECALL restores shadow
        fill(1);
        series(KR);
        check(busy === 1'b1, "R6 recall unlock busy", busy, 1);
        run_busy(cyc, leaks);
        check(cyc == 2 * N, "R7 recall busy length", cyc, 2 * N);
        sweep(0, bad);
        check(bad == 0, "R7 recall contents", bad, 0);

        // R7: shadow unchanged, repeat recall
        fill(2);
        series(KR); run_busy(cyc, leaks);
        sweep(0, bad);
        check(bad == 0, "R7 repeated recall", bad, 0);

        // R5: abort by intervening write
        fill(1);
        rd(K0); rd(K1); rd(K2); wr(100, pat(1, 100)); rd(K3); rd(K4); rd(KS);
        check(busy === 1'b0, "R5 abort by write", busy, 0);
        idle();
        // R5: abort by intervening read
        rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(8'h55); rd(KS);
        check(busy === 1'b0, "R5 abort by read", busy, 0);
        idle();
        series(KR); run_busy(cyc, leaks);
        sweep(0, bad);
        check(bad == 0, "R5 aborted series stored nothing", bad, 0);

        // R5: idle gaps do not abort
        fill(1);
        rd(K0); idle(); rd(K1); rd(K2); idle(); idle(); rd(K3); rd(K4); idle(); rd(KS);
        check(busy === 1'b1, "R5 idle gaps keep series", busy, 1);
        run_busy(cyc, leaks);
        fill(2);
        series(KR); run_busy(cyc, leaks);
        sweep(1, bad);
        check(bad == 0, "R5 gapped store contents", bad, 0);

        // R3: power-fail STORE, R9 pwr_up during busy ignored
        fill(2);
        pwr_fail = 1; @(negedge clk);
        check(busy === 1'b1, "R3 store on pwr_fail", busy, 1);
        pwr_up = 1;
        run_busy(cyc, leaks);
        check(cyc == N, "R9 pwr_up ignored while busy", cyc, N);
        pwr_fail = 0; pwr_up = 0; @(negedge clk);

        // R4: power-up RECALL
        fill(0);
        pwr_up = 1; @(negedge clk);
        check(busy === 1'b1, "R4 recall on pwr_up", busy, 1);
        run_busy(cyc, leaks);
        check(cyc == 2 * N, "R4 recall length", cyc, 2 * N);
        sweep(2, bad);
        check(bad == 0, "R4 recall contents", bad, 0);
        pwr_up = 0; @(negedge clk);

        // R11: simultaneous edges, fail wins
        pwr_up = 1; pwr_fail = 1; @(negedge clk);
        run_busy(cyc, leaks);
        check(cyc == N, "R11 pwr_fail priority", cyc, N);
        pwr_up = 0; pwr_fail = 0; @(negedge clk);

        // R11: pwr_up edge beats store unlock in same cycle
        rd(K0); rd(K1); rd(K2); rd(K3); rd(K4);
        pwr_up = 1; rd(KS);
        run_busy(cyc, leaks);
        check(cyc == 2 * N, "R11 pwr_up over unlock", cyc, 2 * N);
        pwr_up = 0; @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule